// File: doc/BRIEF.md
# Programmable Interval Tick Timer

A periodic interrupt source for a system chipset. A 1 kHz reference strobe from an external prescaler paces the block. Software picks the tick rate by writing a reload value: the rate in Hz is 1000 divided by (reload + 1), rounded down. The block turns that rate back into a whole number of reference ticks per period. It raises its interrupt output when each period ends and starts the next period on its own, with no software action.

The interrupt is level-held. Further expiries leave it set, and only an acknowledge clears it. Software acknowledges in one of two ways. It can read the count register, which always returns zero. It can also write a new reload value, which clears the interrupt and restarts the period from zero. The register port is a simple 32-bit read/write strobe interface with byte addresses. The reload register sits at 0x228 and the count register at 0x230.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt output is low and the reload register reads back as 0. A reload of 0 gives a period of one reference tick.
- R2: A write to byte address 0x228 stores the full 32-bit write data. A read of 0x228 returns that value on `rd_data` in the same cycle as `rd_en`.
- R3: For a reload value r below 1000, the period is floor(1000 / floor(1000 / (r+1))) reference ticks, counted from the write. Examples: r=0 gives 1, r=1 gives 2, r=6 gives 7, r=999 gives 1000.
- R4: For a reload value of 1000 or more, the 0 Hz case, the period is 1000 reference ticks. This includes 0xFFFFFFFF.
- R5: The interrupt output goes high at the first clock edge after the reference tick that completes a period.
- R6: After an expiry the timer re-arms at once. The next expiry follows exactly one period later, whether or not the interrupt was acknowledged.
- R7: The interrupt stays high across further expiries until an acknowledge clears it.
- R8: A read of byte address 0x230 returns 0 and clears the interrupt at the next edge. If an expiry happens in the same cycle, the interrupt stays set.
- R9: A write to 0x228 clears the interrupt and restarts the period count from zero. An expiry that falls in the same cycle as the write is discarded.
- R10: Any other address reads as 0. A write to any other address leaves the reload value and the period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle 1 kHz reference strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 14 | Byte address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while `rd_en` is high |
| irq | output | 1 | Level-held interval interrupt |

## Verification
A corrupted period register or phase counter shows up as an interrupt edge one or more reference ticks away from the computed period. The bench reference model catches this within the first period after the corruption, so at most 1000 ticks. A lost or stuck interrupt flag differs from the model on the very next clock edge. A cycle-accurate model tracks the interrupt level every cycle, so acknowledge/expiry collisions are also judged on the same edge. Decode faults show up on `rd_data` in the read cycle, or later as a period that differs from the one written.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Reference ticks per period for a given reload value and reference rate.
  // The rate is ref_hz/(r+1) rounded down; a zero rate becomes the longest period.
  function automatic int unsigned period_ticks(input logic [63:0] r, input int unsigned ref_hz);
    int unsigned hz;
    if (r >= 64'(ref_hz)) return ref_hz;
    hz = ref_hz / (int'(r[31:0]) + 1);
    if (hz == 0) return ref_hz;
    return ref_hz / hz;
  endfunction

endpackage

// File: rtl/tick_timer_regfile.sv
module tick_timer_regfile
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REF_HZ     = 1000,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned RELOAD_OFF = 'h228,
  parameter int unsigned COUNT_OFF  = 'h230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack_o,
  output logic              rd_ack_o,
  output logic [CNT_W-1:0]  period_o
);

  localparam logic [ADDR_W-1:0] RELOAD_A = ADDR_W'(RELOAD_OFF);
  localparam logic [ADDR_W-1:0] COUNT_A  = ADDR_W'(COUNT_OFF);

  logic [DATA_W-1:0] reload_q;
  logic [CNT_W-1:0]  period_q;
  logic              hit_reload;

  assign hit_reload = (addr == RELOAD_A);
  assign wr_ack_o   = wr_en && hit_reload;
  assign rd_ack_o   = rd_en && (addr == COUNT_A);

  // The period is worked out once, when the reload is written.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      period_q <= CNT_W'(1);
    end else if (wr_ack_o) begin
      reload_q <= wr_data;
      period_q <= CNT_W'(period_ticks(64'(wr_data), REF_HZ));
    end
  end

  // The count register reads as zero, like any undecoded address.
  always_comb begin
    rd_data = '0;
    if (rd_en && hit_reload) rd_data = reload_q;
  end

  assign period_o = period_q;

  // R3 and R4: the stored period is always a legal, non-zero tick count.
  a_r4_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q != '0) && (32'(period_q) <= REF_HZ));

  // R10: the period changes only after a reload write.
  a_r10_period_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack_o |=> $stable(period_q));

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             last_w;

  assign last_w   = (cnt_q == period_i - CNT_W'(1));
  assign expire_o = ref_tick && last_w && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (ref_tick)   cnt_q <= last_w ? '0 : cnt_q + CNT_W'(1);
  end

  // R6: the phase never passes the end of the period.
  a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period_i);

  // R9: a reload write restarts the phase from zero.
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);

  // R6: an expiry re-arms the phase at zero.
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_q == '0);

endmodule

// File: rtl/tick_timer_flag.sv
module tick_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic wr_ack_i,
  input  logic rd_ack_i,
  output logic irq_o
);

  logic irq_q;

  // Precedence: reload write, then expiry, then count read.
  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (wr_ack_i) irq_q <= 1'b0;
    else if (expire_i) irq_q <= 1'b1;
    else if (rd_ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r5_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> irq_q);

  a_r7_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !wr_ack_i && !rd_ack_i |=> irq_q);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_i && !expire_i |=> !irq_q);

  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack_i |=> !irq_q);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REF_HZ     = 1000,
  parameter int unsigned RELOAD_OFF = 'h228,
  parameter int unsigned COUNT_OFF  = 'h230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(REF_HZ + 1);

  logic             wr_ack_w;
  logic             rd_ack_w;
  logic             expire_w;
  logic [CNT_W-1:0] period_w;

  tick_timer_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_HZ(REF_HZ), .CNT_W(CNT_W),
    .RELOAD_OFF(RELOAD_OFF), .COUNT_OFF(COUNT_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .wr_ack_o(wr_ack_w),
    .rd_ack_o(rd_ack_w), .period_o(period_w)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .restart_i(wr_ack_w),
    .period_i(period_w), .expire_o(expire_w)
  );

  tick_timer_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire_i(expire_w), .wr_ack_i(wr_ack_w),
    .rd_ack_i(rd_ack_w), .irq_o(irq)
  );

  // R1: no interrupt can appear without a completed period behind it.
  a_r1_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire_w));

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int TICK_GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit tick_on = 0;
  bit done = 0;

  logic [31:0] exp_rd_q[$];

  // Reference model state
  logic [31:0] m_reload;
  int          m_period;
  int          m_phase;
  bit          m_irq;
  int          ticks_since_wr;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  // Period from the rate definition, computed by repeated counting.
  function automatic int ref_period(input logic [31:0] r);
    longint hz = 0;
    longint p = 0;
    longint step = longint'(r) + 1;
    while ((hz + 1) * step <= 1000) hz++;
    if (hz == 0) return 1000;
    while ((p + 1) * hz <= 1000) p++;
    return int'(p);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Model update, using inputs held stable around the edge
  always @(posedge clk) begin
    bit w, r, ex;
    if (!rst_n) begin
      m_reload = 0; m_period = 1; m_phase = 0; m_irq = 0; ticks_since_wr = 0;
    end else begin
      w  = wr_en && addr == 14'h228;
      r  = rd_en && addr == 14'h230;
      ex = ref_tick && !w && (m_phase == m_period - 1);
      if (w) begin
        m_reload = wr_data; m_period = ref_period(wr_data);
        m_phase = 0; m_irq = 0; ticks_since_wr = 0;
      end else begin
        if (ref_tick) begin
          ticks_since_wr++;
          m_phase = ex ? 0 : m_phase + 1;
        end
        if (ex) m_irq = 1;
        else if (r) m_irq = 0;
      end
    end
  end

  // Monitor: per-cycle interrupt comparison and read scoreboard (R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    logic [31:0] e;
    if (rst_n && !done) begin
      check(irq == m_irq, "R5/R7 irq model", irq, m_irq);
      if (rd_en) begin
        if (exp_rd_q.size() == 0) check(0, "R2 scoreboard empty", rd_data, 0);
        else begin
          e = exp_rd_q.pop_front();
          check(rd_data == e, "R2/R8/R10 read data", rd_data, e);
        end
      end
    end
  end

  // Reference strobe generator
  initial begin
    forever begin
      @(posedge clk); #2;
      ref_tick = tick_on && (cyc % TICK_GAP == 0);
    end
  end

  always @(posedge clk) cyc++;

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] expv);
    @(posedge clk); #2;
    rd_en = 1; addr = a;
    exp_rd_q.push_back(expv);
    @(posedge clk); #2;
    rd_en = 0;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic measure(input logic [31:0] r, input string req);
    bit ok;
    int expv;
    expv = ref_period(r);
    wr(14'h228, r);
    wait_irq(ok);
    check(ok && ticks_since_wr == expv, req, ticks_since_wr, expv);
  endtask

  initial begin
    bit ok;
    int t1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(irq == 0, "R1 irq low after reset", irq, 0);
    rd(14'h228, 32'h0);
    repeat (5) @(negedge clk);
    check(irq == 0, "R1 no irq without ticks", irq, 0);

    // R2 readback
    wr(14'h228, 32'h1234abcd);
    rd(14'h228, 32'h1234abcd);

    tick_on = 1;
    // R3 periods below the cap (R1: reload 0 gives one tick)
    measure(32'd0,   "R3 reload 0");
    measure(32'd1,   "R3 reload 1");
    measure(32'd2,   "R3 reload 2");
    measure(32'd6,   "R3 reload 6");
    measure(32'd333, "R3 reload 333");
    measure(32'd999, "R3 reload 999");
    // R4 the zero-rate cap
    measure(32'd1000,       "R4 reload 1000");
    measure(32'hFFFF_FFFF,  "R4 reload max");

    // R6 re-arm after acknowledge by read (R8 returns zero)
    measure(32'd2, "R6 first expiry");
    rd(14'h230, 32'h0);
    @(negedge clk);
    t1 = ticks_since_wr;
    wait_irq(ok);
    check(ok && ticks_since_wr == 6, "R6 second expiry one period later", ticks_since_wr, 6);

    // R7 level held across several expiries
    measure(32'd0, "R7 setup");
    repeat (5 * TICK_GAP) @(negedge clk);
    check(irq == 1, "R7 held over expiries", irq, 1);

    // R8 read of count clears (reload 999: no expiry nearby)
    measure(32'd999, "R8 setup");
    rd(14'h230, 32'h0);
    @(negedge clk);
    check(irq == 0, "R8 read clears irq", irq, 1'b0);

    // R9 write clears and restarts
    measure(32'd4, "R9 setup");
    wr(14'h228, 32'd999);
    @(negedge clk);
    check(irq == 0, "R9 write clears irq", irq, 0);
    wait_irq(ok);
    check(ok && ticks_since_wr == 1000, "R9 restart from zero", ticks_since_wr, 1000);

    // R10 other addresses
    wr(14'h22C, 32'd0);
    wr(14'h229, 32'd0);
    rd(14'h228, 32'd999);
    rd(14'h220, 32'h0);
    rd(14'h231, 32'h0);
    rd(14'h230, 32'h0);
    wait_irq(ok);
    check(ok && ticks_since_wr == 2000, "R10 period unchanged by stray writes", ticks_since_wr, 2000);

    repeat (4) @(negedge clk);
    done = 1;
    check(exp_rd_q.size() == 0, "R2 scoreboard drained", exp_rd_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule